// File: doc/BRIEF.md
# Polled Keyboard Capture Registers

This peripheral sits on a simple synchronous byte bus and captures key codes from a one-cycle key-event strobe. Two byte registers are visible to software: a ready byte that reads 1 once a key has arrived, and a code byte that holds the character code of the most recent key.

Software polls the ready byte until it is nonzero, then reads the code byte. Reading the code byte does not clear the ready byte. To acknowledge the key, software writes zero to the ready byte. The hardware event path takes priority over this acknowledge. If keys arrive faster than software reads them, the newest code replaces the older one.

Top module: `kbd_capture_regs`

## Requirements
- R1: After reset, the ready byte and the code byte both read 0, and `bus_rdata` is 0 while reset is held.
- R2: A cycle with `key_valid` high loads `key_code` into the code byte (address 0xF801). It also sets the ready byte (address 0xF800) to 0x01.
- R3: Reading either register leaves the ready byte unchanged.
- R4: A bus write of 0x00 to 0xF800 clears the ready byte to 0x00. The code byte is left as it was.
- R5: A bus write of a nonzero value to 0xF800 has no effect. The ready byte only ever reads 0x00 or 0x01.
- R6: A key event that arrives while the ready byte is 0x01 replaces the code byte with the new code, and the ready byte stays 0x01.
- R7: When a key event and a write of 0x00 to 0xF800 occur in the same cycle, the key event wins. The ready byte ends at 0x01 and the code byte holds the new code.
- R8: Bus writes to 0xF801 are ignored, and the code byte keeps its value.
- R9: Reads of any address other than 0xF800 and 0xF801 return 0x00.
- R10: `bus_rdata` is registered. It shows, one cycle after the address is presented, the register value from before any update made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe marking a key event |
| key_code | input | 8 | Character code of the key event |
| bus_addr | input | 16 | Byte address for the read or write |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the address |

## Verification
The bench sends a key event in the same cycle as an acknowledge write. A design that gives the acknowledge priority would read back 0 and lose the key. It also writes nonzero values to the ready byte and any value to the code byte. A decoder that ignores the data value or the address would clear or corrupt state that should persist. Back-to-back keys with no acknowledge in between catch a design that drops the newer code. A read issued in the same cycle as a key event catches a design whose read data bypasses the register and shows the post-update value.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  ready;
        byte_t code;
    } kcr_state_t;
endpackage

// File: rtl/kcr_latch.sv
module kcr_latch
    import kcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  key_valid,
    input  byte_t key_code,
    input  logic  ack_wr,
    output logic  ready_o,
    output byte_t code_o
);
    kcr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_valid) begin
            st_d.ready = 1'b1;
            st_d.code  = key_code;
        end else if (ack_wr) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;
    assign code_o  = st_q.code;

    p_key_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (ready_o && code_o == $past(key_code)));
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !key_valid) |=> !ready_o);
    p_key_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && key_valid) |=> ready_o);
    p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && !key_valid) |=> $stable(ready_o));
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> $stable(code_o));
endmodule

// File: rtl/kcr_busport.sv
module kcr_busport
    import kcr_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] READY_ADDR = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  byte_t             bus_wdata,
    input  logic              ready_i,
    input  byte_t             code_i,
    output logic              ack_wr_o,
    output byte_t             rdata_o
);
    localparam logic [ADDR_W-1:0] RDY_A  = READY_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CODE_A = RDY_A + 1'b1;

    byte_t rdata_d, rdata_q;
    logic  hit_rdy, hit_code;

    always_comb begin
        hit_rdy  = (bus_addr == RDY_A);
        hit_code = (bus_addr == CODE_A);
        ack_wr_o = bus_we && hit_rdy && (bus_wdata == 8'h00);
        rdata_d  = 8'h00;
        if (hit_rdy)       rdata_d = {7'b0, ready_i};
        else if (hit_code) rdata_d = code_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != RDY_A && bus_addr != CODE_A) |=> (rdata_o == 8'h00));
    p_ready_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RDY_A) |=> (rdata_o == {7'b0, $past(ready_i)}));
    p_code_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CODE_A) |=> (rdata_o == $past(code_i)));
    p_ack_needs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata != 8'h00) |-> !ack_wr_o);
endmodule

// File: rtl/kbd_capture_regs.sv
module kbd_capture_regs
    import kcr_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] READY_ADDR = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [7:0]        key_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic  ack_wr;
    logic  ready;
    byte_t code;

    kcr_latch i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .ack_wr    (ack_wr),
        .ready_o   (ready),
        .code_o    (code)
    );

    kcr_busport #(
        .ADDR_W     (ADDR_W),
        .READY_ADDR (READY_ADDR)
    ) i_busport (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .ready_i   (ready),
        .code_i    (code),
        .ack_wr_o  (ack_wr),
        .rdata_o   (bus_rdata)
    );

    p_rdata_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == 8'h00));
endmodule

// File: tb/test_kbd_capture_regs.sv
module test_kbd_capture_regs;
    localparam logic [15:0] A_RDY  = 16'hF800;
    localparam logic [15:0] A_CODE = 16'hF801;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_code = 8'h00;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    logic       m_rdy  = 1'b0;
    logic [7:0] m_code = 8'h00;

    always #2 clk = ~clk;

    kbd_capture_regs i_kbd_capture_regs (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Monitor: pops one expected read per cycle, just after the edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
            end
        end
    end

    // Driver: one bus cycle; expected read value from the spec model
    task automatic cyc(input logic kv, input logic [7:0] kc, input logic we,
                       input logic [15:0] a, input logic [7:0] wd,
                       input logic chk, input string tag);
        @(negedge clk);
        key_valid = kv; key_code = kc; bus_we = we; bus_addr = a; bus_wdata = wd;
        if (chk) begin
            q_exp.push_back(a == A_RDY ? {7'b0, m_rdy} : (a == A_CODE ? m_code : 8'h00));
            q_tag.push_back(tag);
        end
        if (kv) begin
            m_code = kc;
            m_rdy  = 1'b1;
        end else if (we && a == A_RDY && wd == 8'h00) begin
            m_rdy = 1'b0;
        end
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        cyc(1'b0, 8'h00, 1'b0, a, 8'h00, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 8'h00) begin
            fails++;
            $display("FAIL R1: rdata in reset=%02h expected=00", bus_rdata);
        end
        rst_n = 1'b1;
        rd(A_RDY, "R1 ready after reset");
        rd(A_CODE, "R1 code after reset");
        rd(16'h1234, "R9 unmapped");

        cyc(1'b1, 8'h41, 1'b0, 16'h0000, 8'h00, 1'b0, "");
        rd(A_RDY, "R2 ready set");
        rd(A_CODE, "R2 code loaded");
        rd(A_CODE, "R3 second code read");
        rd(A_RDY, "R3 ready kept after reads");

        cyc(1'b0, 8'h00, 1'b1, A_RDY, 8'h05, 1'b0, "");
        rd(A_RDY, "R5 nonzero write ignored");
        cyc(1'b0, 8'h00, 1'b1, A_CODE, 8'h77, 1'b0, "");
        rd(A_CODE, "R8 code write ignored");
        cyc(1'b0, 8'h00, 1'b1, A_CODE, 8'h00, 1'b0, "");
        rd(A_CODE, "R8 zero code write ignored");

        cyc(1'b0, 8'h00, 1'b1, A_RDY, 8'h00, 1'b0, "");
        rd(A_RDY, "R4 ack clears ready");
        rd(A_CODE, "R4 code kept after ack");

        cyc(1'b1, 8'h42, 1'b0, 16'h0000, 8'h00, 1'b0, "");
        cyc(1'b1, 8'h43, 1'b0, 16'h0000, 8'h00, 1'b0, "");
        rd(A_RDY, "R6 ready stays set");
        rd(A_CODE, "R6 newest code");

        cyc(1'b1, 8'h44, 1'b1, A_RDY, 8'h00, 1'b0, "");
        rd(A_RDY, "R7 key wins over ack");
        rd(A_CODE, "R7 code from key");

        cyc(1'b0, 8'h00, 1'b1, A_RDY, 8'h00, 1'b0, "");
        cyc(1'b1, 8'h55, 1'b0, A_RDY, 8'h00, 1'b1, "R10 read sees pre-update ready");
        rd(A_RDY, "R10 ready next read");
        cyc(1'b1, 8'h66, 1'b0, A_CODE, 8'h00, 1'b1, "R10 read sees pre-update code");
        rd(A_CODE, "R10 code next read");

        rd(16'hF802, "R9 above window");
        rd(16'hF7FF, "R9 below window");

        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 8'h00, 1'b1, A_RDY, 8'h00, 1'b0, "");
            cyc(1'b1, 8'(i * 37 + 1), 1'b0, 16'h0000, 8'h00, 1'b0, "");
            rd(A_RDY, "R2 ready in sweep");
            rd(A_CODE, "R2 code in sweep");
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule